// File: doc/BRIEF.md
# Scaled-Index Shift-and-Add Unit

This execution unit forms a scaled-index value: an index operand is shifted left by a small amount and added to a base operand, giving a 64-bit result that wraps modulo 2^64. It is the arithmetic core behind address computations such as base plus element offset times element size, and it also serves plain arithmetic.

Two operations are offered. The full-width form shifts all 64 bits of the index. The word form keeps only the low 32 bits of the index, zero-extends them to 64 bits and then shifts, so a 32-bit unsigned offset can be added to a 64-bit base. The shift is given by a 2-bit field holding the amount minus one, so the shift always lies between 1 and 4.

The unit has a single register stage with a valid/ready handshake on both sides. A request is taken when the input valid and ready are both high. Its result appears on the next cycle and stays stable until the consumer accepts it.

Top module: `scaled_add_unit`

## Requirements
- R1: The 2-bit field `inShiftCode` selects a left shift of `inShiftCode + 1`: 0 gives 1, 1 gives 2, 2 gives 3 and 3 gives 4. A shift of zero cannot be requested.
- R2: When `inOpWord` is 0 (full-width form), the result is `(inIndex << (inShiftCode+1)) + inBase`, and all 64 bits of `inIndex` take part.
- R3: When `inOpWord` is 1 (word form), only `inIndex[31:0]` is used. It is zero-extended to 64 bits, never sign-extended, before the shift. An index of 0x0000_0000_8000_0000 with a shift of 1 therefore adds 0x1_0000_0000.
- R4: In the word form the shift is applied after zero-extension, so index bits can reach result bits 32 to 35 and are not lost.
- R5: The result is 64 bits wide. Any bits shifted or carried out above bit 63 are discarded, so the result wraps modulo 2^64.
- R6: A request is accepted on a rising clock edge where `inValid` and `inReady` are both high. Its result is presented with `outValid` high from the next cycle on.
- R7: While `outValid` is high and `outReady` is low, `outResult` and `outValid` hold. `inReady` is high exactly when the output register is empty or `outReady` is high.
- R8: The operation select, shift field and operands are captured at acceptance. Input changes after acceptance do not alter a pending result.
- R9: After reset, `outValid` is low and `inReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Request present |
| inReady | output | 1 | Unit can take a request |
| inOpWord | input | 1 | 0 selects the full-width form, 1 selects the word form |
| inShiftCode | input | 2 | Shift amount minus one |
| inBase | input | 64 | Base operand |
| inIndex | input | 64 | Index operand |
| outValid | output | 1 | Result present |
| outReady | input | 1 | Consumer takes the result |
| outResult | output | 64 | Shifted index plus base |

## Verification
The bench uses the default widths: a 64-bit datapath, a 32-bit word index and a 2-bit shift field. With these values every shift code can be driven in both forms. They also make the bit-31 zero-extension corner, all-ones wraparound and index bits landing in bits 32 to 35 directly observable. A random stretch of `outReady` low periods holds results in place, which lets the bench check hold behaviour and check that a pending result does not follow input changes.

// File: rtl/scaled_add_pkg.sv
package scaled_add_pkg;
  typedef struct packed {
    logic load;
    logic clear;
  } ctrl_strobes_t;
endpackage

// File: rtl/scaled_add_ctrl.sv
module scaled_add_ctrl
  import scaled_add_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  output logic          inReady,
  output logic          outValid,
  input  logic          outReady,
  output ctrl_strobes_t strobes
);
  logic fullQ;

  assign inReady       = !fullQ || outReady;
  assign strobes.load  = inValid && inReady;
  assign strobes.clear = fullQ && outReady && !strobes.load;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fullQ <= 1'b0;
    end else if (strobes.load) begin
      fullQ <= 1'b1;
    end else if (strobes.clear) begin
      fullQ <= 1'b0;
    end
  end

  assign outValid = fullQ;
endmodule

// File: rtl/scaled_add_dp.sv
module scaled_add_dp
  import scaled_add_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int WORD_W  = 32,
  parameter int SHIFT_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_strobes_t      strobes,
  input  logic               opWord,
  input  logic [SHIFT_W-1:0] shiftCode,
  input  logic [DATA_W-1:0]  base,
  input  logic [DATA_W-1:0]  index,
  output logic [DATA_W-1:0]  result
);
  localparam int AMT_W = SHIFT_W + 1;

  logic [DATA_W-1:0] indexSel;
  logic [AMT_W-1:0]  shiftAmt;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] resultQ;

  // Zero-extend the low word in word form; never replicate bit WORD_W-1.
  always_comb begin
    indexSel = index;
    if (opWord) indexSel = {{(DATA_W-WORD_W){1'b0}}, index[WORD_W-1:0]};
  end

  assign shiftAmt = AMT_W'(shiftCode) + AMT_W'(1);
  assign shifted  = indexSel << shiftAmt;
  assign sum      = shifted + base;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ <= '0;
    end else if (strobes.load) begin
      resultQ <= sum;
    end
  end

  assign result = resultQ;
endmodule

// File: rtl/scaled_add_unit.sv
module scaled_add_unit
  import scaled_add_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int WORD_W  = 32,
  parameter int SHIFT_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  output logic               inReady,
  input  logic               inOpWord,
  input  logic [SHIFT_W-1:0] inShiftCode,
  input  logic [DATA_W-1:0]  inBase,
  input  logic [DATA_W-1:0]  inIndex,
  output logic               outValid,
  input  logic               outReady,
  output logic [DATA_W-1:0]  outResult
);
  ctrl_strobes_t strobes;

  scaled_add_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .strobes(strobes)
  );

  scaled_add_dp #(.DATA_W(DATA_W), .WORD_W(WORD_W), .SHIFT_W(SHIFT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .opWord(inOpWord),
    .shiftCode(inShiftCode), .base(inBase), .index(inIndex), .result(outResult)
  );
endmodule

// File: rtl/scaled_add_checker.sv
module scaled_add_checker #(
  parameter int DATA_W  = 64,
  parameter int WORD_W  = 32,
  parameter int SHIFT_W = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic               inReady,
  input logic               inOpWord,
  input logic [SHIFT_W-1:0] inShiftCode,
  input logic [DATA_W-1:0]  inBase,
  input logic [DATA_W-1:0]  inIndex,
  input logic               outValid,
  input logic               outReady,
  input logic [DATA_W-1:0]  outResult
);
  function automatic logic [DATA_W-1:0] model(input logic w, input logic [SHIFT_W-1:0] s,
                                              input logic [DATA_W-1:0] b, input logic [DATA_W-1:0] i);
    logic [DATA_W-1:0] x;
    x = w ? {{(DATA_W-WORD_W){1'b0}}, i[WORD_W-1:0]} : i;
    return (x << (int'(s) + 1)) + b;
  endfunction

  // R2, R3, R4, R5, R8: registered result equals the model of the accepted inputs
  a_r2_result_matches: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> (outResult == model($past(inOpWord), $past(inShiftCode),
                                                 $past(inBase), $past(inIndex))));
  // R6: accepted request gives valid output next cycle
  a_r6_valid_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid);
  // R7: stalled output holds
  a_r7_hold_when_stalled: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outResult)));
  // R7: ready follows occupancy and consumer
  a_r7_ready_rule: assert property (@(posedge clk) disable iff (!rstN)
    inReady == (!outValid || outReady));
  // R9: empty output register offers ready
  a_r9_empty_ready: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> inReady);
endmodule

bind scaled_add_unit scaled_add_checker #(.DATA_W(DATA_W), .WORD_W(WORD_W), .SHIFT_W(SHIFT_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inOpWord(inOpWord),
  .inShiftCode(inShiftCode), .inBase(inBase), .inIndex(inIndex), .outValid(outValid),
  .outReady(outReady), .outResult(outResult)
);

// File: tb/scaled_add_unit_bench.sv
module scaled_add_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic        inOpWord = 1'b0;
  logic [1:0]  inShiftCode = 2'd0;
  logic [63:0] inBase = '0;
  logic [63:0] inIndex = '0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [63:0] outResult;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  scaled_add_unit u_scaled_add_unit (.*);

  function automatic logic [63:0] expect_val(input logic w, input logic [1:0] s,
                                             input logic [63:0] b, input logic [63:0] i);
    logic [63:0] x;
    x = w ? {32'h0, i[31:0]} : i;
    return (x << (s + 1)) + b;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one request and stall the output for `stall` cycles before taking it.
  task automatic run_op(input string req, input logic w, input logic [1:0] s,
                        input logic [63:0] b, input logic [63:0] i, input int stall);
    logic [63:0] e;
    e = expect_val(w, s, b, i);
    @(negedge clk);
    inValid = 1'b1; inOpWord = w; inShiftCode = s; inBase = b; inIndex = i; outReady = 1'b0;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    inOpWord = ~w; inShiftCode = ~s; inBase = ~b; inIndex = ~i;  // R8 disturbance
    check({req, " R6 valid"}, 64'(outValid), 64'd1);
    check(req, outResult, e);
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      check({req, " R7 hold"}, outResult, e);
      check("R7 inReady low while stalled", 64'(inReady), 64'd0);
    end
    check({req, " R8 after input change"}, outResult, e);
    outReady = 1'b1;
    @(negedge clk);
    check("R6 drained", 64'(outValid), 64'd0);
    outReady = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 outValid at reset", 64'(outValid), 64'd0);
    check("R9 inReady at reset", 64'(inReady), 64'd1);
    rstN = 1'b1;
    // R1: each shift code, full width
    for (int s = 0; s < 4; s++)
      run_op("R1 shift code", 1'b0, 2'(s), 64'd5, 64'd3, 0);
    // R2: full-width uses upper bits
    run_op("R2 full width", 1'b0, 2'd0, 64'h10, 64'h0000_0001_0000_0003, 1);
    check("R2 literal", expect_val(1'b0, 2'd0, 64'h10, 64'h0000_0001_0000_0003), 64'h0000_0002_0000_0016);
    // R3: zero extension corner
    run_op("R3 word zext", 1'b1, 2'd0, 64'd0, 64'h0000_0000_8000_0000, 0);
    check("R3 literal", expect_val(1'b1, 2'd0, 64'd0, 64'h8000_0000), 64'h0000_0001_0000_0000);
    run_op("R3 upper ignored", 1'b1, 2'd1, 64'd1, 64'hDEAD_BEEF_0000_0010, 2);
    // R4: shift after extension
    run_op("R4 bits into 35:32", 1'b1, 2'd3, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 0);
    check("R4 literal", expect_val(1'b1, 2'd3, 64'd0, '1), 64'h0000_000F_FFFF_FFF0);
    // R5: wraparound
    run_op("R5 wrap", 1'b0, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1);
    check("R5 literal", expect_val(1'b0, 2'd0, 64'd1, 64'h8000_0000_0000_0000), 64'd1);
    // Random stimulus
    void'($urandom(32'h5eed));
    for (int n = 0; n < 200; n++)
      run_op("R2 R3 random", 1'($urandom), 2'($urandom), {$urandom, $urandom},
             {$urandom, $urandom}, int'($urandom % 3));
    // R7: back-to-back with outReady high
    @(negedge clk);
    outReady = 1'b1; inValid = 1'b1; inOpWord = 1'b0; inShiftCode = 2'd1;
    inBase = 64'd7; inIndex = 64'd2;
    @(negedge clk);
    check("R7 streaming result a", outResult, 64'd15);
    check("R7 ready while draining", 64'(inReady), 64'd1);
    inIndex = 64'd4;
    @(negedge clk);
    inValid = 1'b0;
    check("R7 streaming result b", outResult, 64'd23);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule